// File: doc/BRIEF.md
# Refresh-Masked Parity Read Recovery

This block sits on the read and write data paths of a memory rank. The rank holds `NUM_DEV` data devices and one extra device that stores XOR parity. A column read returns one lane per device, and each lane is as wide as one device. One device at a time may be taken away for refresh. A one-hot busy mask names that device. When the busy device is a data device, the block rebuilds its lane from the XOR of every other lane, parity included. The read therefore completes during the refresh and does not wait for it to end. When the busy device is the parity device, the data lanes pass straight through.

On the write side the block takes the data lanes and appends the parity lane. While any device is busy it holds writes off, because the busy device cannot take its share of the data.

Both directions use valid/ready handshakes with one register stage. An accepted beat appears on the output at the next clock edge, whether or not a lane was rebuilt. A beat moves on any edge where valid and ready are both high. While the output holds a beat that has not been taken, its data stays frozen. An input is accepted only when that output stage is empty or is draining in the same cycle.

Top module: `refresh_parity_recover`

## Requirements
- R1: After reset, `rd_out_valid` and `wr_out_valid` are low.
- R2: With `refresh_busy` all zero, the read data output equals data lanes 0..NUM_DEV-1 of the accepted beat unchanged. Lane i occupies bits [i*LANE_W +: LANE_W], and the parity lane is lane NUM_DEV, the top lane of `rd_in_lanes`.
- R3: With bit k of `refresh_busy` set (k < NUM_DEV), output lane k equals the XOR of every other lane of the beat, parity included. The beat's own lane k has no effect, and all other lanes pass unchanged.
- R4: With bit NUM_DEV of `refresh_busy` set, the data lanes pass unchanged and the parity lane has no effect.
- R5: A read beat accepted on a clock edge is presented with `rd_out_valid` high after that same edge, whether or not recovery was applied, and no output beat appears without an accepted input.
- R6: While an output holds a beat with its ready low, the beat's data stays stable and the matching input ready is low.
- R7: A written beat appears on `wr_out_lanes` one edge after acceptance. Lanes 0..NUM_DEV-1 copy `wr_in_data`, and lane NUM_DEV is the XOR of all data lanes.
- R8: While any bit of `refresh_busy` is set, `wr_in_ready` is low and no write is accepted. With no bit set and the write output stage empty, `wr_in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_busy | input | NUM_DEV+1 | One-hot0 mask of the device under refresh; the top bit is the parity device |
| rd_in_valid | input | 1 | Raw column read beat valid |
| rd_in_ready | output | 1 | Read beat accepted when high together with valid |
| rd_in_lanes | input | (NUM_DEV+1)*LANE_W | All device lanes of the read; parity in the top lane |
| rd_out_valid | output | 1 | Recovered read data valid |
| rd_out_ready | input | 1 | Downstream accepts read data |
| rd_out_data | output | NUM_DEV*LANE_W | Recovered data lanes |
| wr_in_valid | input | 1 | Write beat valid |
| wr_in_ready | output | 1 | Write beat accepted when high together with valid |
| wr_in_data | input | NUM_DEV*LANE_W | Write data lanes |
| wr_out_valid | output | 1 | Encoded write beat valid |
| wr_out_ready | input | 1 | Device side accepts the write beat |
| wr_out_lanes | output | (NUM_DEV+1)*LANE_W | Data lanes plus the parity lane on top |

## Verification
The assertions assume that `refresh_busy` never has more than one bit set. They also assume that the read lanes other than the busy one are parity-consistent, as the devices would return them. The random stimulus keeps both rules. It draws the busy mask as zero or as a single random bit, builds every read beat from stored data with matching parity, and then corrupts only the busy device's lane. Ready and valid on both sides are randomised so that back-pressure and stalls under refresh occur throughout the run.

// File: rtl/refresh_parity_pkg.sv
package refresh_parity_pkg;

  typedef enum logic [1:0] {
    LANE_PASS    = 2'd0,
    LANE_REBUILD = 2'd1
  } lane_src_e;

  function automatic int unsigned lane_lo(input int unsigned idx, input int unsigned width);
    return idx * width;
  endfunction

endpackage

// File: rtl/parity_fold.sv
module parity_fold #(
  parameter int unsigned NUM_LANES = 9,
  parameter int unsigned LANE_W    = 8
) (
  input  logic [NUM_LANES*LANE_W-1:0] lanes_i,
  output logic [LANE_W-1:0]           fold_o
);
  always_comb begin
    fold_o = '0;
    for (int unsigned i = 0; i < NUM_LANES; i++) begin
      fold_o = fold_o ^ lanes_i[i*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/lane_rebuild.sv
module lane_rebuild
  import refresh_parity_pkg::*;
#(
  parameter int unsigned NUM_DEV = 8,
  parameter int unsigned LANE_W  = 8
) (
  input  logic [(NUM_DEV+1)*LANE_W-1:0] lanes_i,
  input  logic [NUM_DEV:0]              busy_i,
  output logic [NUM_DEV*LANE_W-1:0]     data_o
);
  localparam int unsigned TOTAL = NUM_DEV + 1;

  logic [TOTAL*LANE_W-1:0] masked;
  logic [LANE_W-1:0]       syndrome;

  // The busy device's lane is zeroed before folding, so the fold is the
  // XOR of all surviving lanes (parity included).
  for (genvar g = 0; g < TOTAL; g++) begin : g_mask
    localparam int unsigned LO = lane_lo(g, LANE_W);
    assign masked[LO +: LANE_W] = busy_i[g] ? '0 : lanes_i[LO +: LANE_W];
  end

  parity_fold #(.NUM_LANES(TOTAL), .LANE_W(LANE_W)) u_fold (
    .lanes_i (masked),
    .fold_o  (syndrome)
  );

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_sel
    localparam int unsigned LO = lane_lo(g, LANE_W);
    lane_src_e src;
    assign src = busy_i[g] ? LANE_REBUILD : LANE_PASS;
    assign data_o[LO +: LANE_W] = (src == LANE_REBUILD) ? syndrome : lanes_i[LO +: LANE_W];
  end
endmodule

// File: rtl/beat_stage.sv
module beat_stage #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      out_data <= in_data;
    end
  end

  // R5
  load_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: rtl/refresh_parity_recover.sv
module refresh_parity_recover #(
  parameter int unsigned NUM_DEV = 8,
  parameter int unsigned LANE_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_DEV:0]              refresh_busy,
  input  logic                          rd_in_valid,
  output logic                          rd_in_ready,
  input  logic [(NUM_DEV+1)*LANE_W-1:0] rd_in_lanes,
  output logic                          rd_out_valid,
  input  logic                          rd_out_ready,
  output logic [NUM_DEV*LANE_W-1:0]     rd_out_data,
  input  logic                          wr_in_valid,
  output logic                          wr_in_ready,
  input  logic [NUM_DEV*LANE_W-1:0]     wr_in_data,
  output logic                          wr_out_valid,
  input  logic                          wr_out_ready,
  output logic [(NUM_DEV+1)*LANE_W-1:0] wr_out_lanes
);
  localparam int unsigned DATA_W = NUM_DEV * LANE_W;
  localparam int unsigned FULL_W = (NUM_DEV + 1) * LANE_W;

  // Read path: rebuild, then one register stage.
  logic [DATA_W-1:0] rd_fixed;

  lane_rebuild #(.NUM_DEV(NUM_DEV), .LANE_W(LANE_W)) u_rebuild (
    .lanes_i (rd_in_lanes),
    .busy_i  (refresh_busy),
    .data_o  (rd_fixed)
  );

  beat_stage #(.WIDTH(DATA_W)) u_rd_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rd_in_valid),
    .in_ready  (rd_in_ready),
    .in_data   (rd_fixed),
    .out_valid (rd_out_valid),
    .out_ready (rd_out_ready),
    .out_data  (rd_out_data)
  );

  // Write path: parity encode, gated while any device refreshes.
  logic              any_busy;
  logic [LANE_W-1:0] wr_parity;
  logic              wr_stage_valid;
  logic              wr_stage_ready;

  assign any_busy = |refresh_busy;

  parity_fold #(.NUM_LANES(NUM_DEV), .LANE_W(LANE_W)) u_wr_fold (
    .lanes_i (wr_in_data),
    .fold_o  (wr_parity)
  );

  assign wr_stage_valid = wr_in_valid && !any_busy;
  assign wr_in_ready    = wr_stage_ready && !any_busy;

  beat_stage #(.WIDTH(FULL_W)) u_wr_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (wr_stage_valid),
    .in_ready  (wr_stage_ready),
    .in_data   ({wr_parity, wr_in_data}),
    .out_valid (wr_out_valid),
    .out_ready (wr_out_ready),
    .out_data  (wr_out_lanes)
  );

  // Checker fold: a consistent stored beat XORs to zero across all lanes.
  logic [LANE_W-1:0] wr_out_fold;
  parity_fold #(.NUM_LANES(NUM_DEV + 1), .LANE_W(LANE_W)) u_chk_fold (
    .lanes_i (wr_out_lanes),
    .fold_o  (wr_out_fold)
  );

  // R3
  busy_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(refresh_busy));

  // R8
  wr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_busy |-> !wr_in_ready);

  // R7
  parity_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out_valid |-> (wr_out_fold == '0));

  // R2
  clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_in_valid && rd_in_ready && !any_busy) |=> (rd_out_data == $past(rd_in_lanes[DATA_W-1:0])));

  // R4
  parity_busy_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_in_valid && rd_in_ready && refresh_busy[NUM_DEV]) |=> (rd_out_data == $past(rd_in_lanes[DATA_W-1:0])));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!rd_out_valid && !wr_out_valid));
endmodule

// File: tb/refresh_parity_recover_tb.sv
`timescale 1ns/1ps
module refresh_parity_recover_tb;
  localparam int N  = 8;
  localparam int W  = 8;
  localparam int DW = N * W;
  localparam int LW = (N + 1) * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N:0]    refresh_busy = '0;
  logic          rd_in_valid = 1'b0, rd_in_ready;
  logic [LW-1:0] rd_in_lanes = '0;
  logic          rd_out_valid, rd_out_ready = 1'b0;
  logic [DW-1:0] rd_out_data;
  logic          wr_in_valid = 1'b0, wr_in_ready;
  logic [DW-1:0] wr_in_data = '0;
  logic          wr_out_valid, wr_out_ready = 1'b0;
  logic [LW-1:0] wr_out_lanes;

  always #4 clk = ~clk;

  refresh_parity_recover #(.NUM_DEV(N), .LANE_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .refresh_busy(refresh_busy),
    .rd_in_valid(rd_in_valid), .rd_in_ready(rd_in_ready), .rd_in_lanes(rd_in_lanes),
    .rd_out_valid(rd_out_valid), .rd_out_ready(rd_out_ready), .rd_out_data(rd_out_data),
    .wr_in_valid(wr_in_valid), .wr_in_ready(wr_in_ready), .wr_in_data(wr_in_data),
    .wr_out_valid(wr_out_valid), .wr_out_ready(wr_out_ready), .wr_out_lanes(wr_out_lanes)
  );

  int vectors = 0;
  int errors  = 0;

  logic [DW-1:0] rd_q[$];
  string         rd_tag_q[$];
  logic [LW-1:0] wr_q[$];
  logic          prev_rd_fire = 1'b0;
  logic          prev_wr_fire = 1'b0;

  function automatic logic [W-1:0] xor_lanes(input logic [DW-1:0] d);
    logic [W-1:0] p = '0;
    for (int i = 0; i < N; i++) p ^= d[i*W +: W];
    return p;
  endfunction

  // What the devices return: stored data with parity, busy lane garbled.
  function automatic logic [LW-1:0] device_lanes(input logic [DW-1:0] d, input logic [N:0] bz);
    logic [LW-1:0] l = {xor_lanes(d), d};
    for (int i = 0; i <= N; i++)
      if (bz[i]) l[i*W +: W] = ~l[i*W +: W];
    return l;
  endfunction

  function automatic string read_tag(input logic [N:0] bz);
    if (bz == '0) return "R2";
    if (bz[N]) return "R4";
    return "R3";
  endfunction

  task automatic check(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic rv, input logic [DW-1:0] rdat, input logic [N:0] bz,
                      input logic wv, input logic [DW-1:0] wdat,
                      input logic rr, input logic wr);
    @(negedge clk);
    // R5: beat accepted on the last edge must be visible now
    if (prev_rd_fire) check("R5", LW'(rd_out_valid), LW'(1));
    if (prev_wr_fire) check("R7", LW'(wr_out_valid), LW'(1));
    refresh_busy = bz;
    rd_in_valid  = rv;
    rd_in_lanes  = device_lanes(rdat, bz);
    wr_in_valid  = wv;
    wr_in_data   = wdat;
    rd_out_ready = rr;
    wr_out_ready = wr;
    #1;
    if (rd_out_valid && !rr) check("R6", LW'(rd_in_ready), LW'(0));
    if (bz != '0) check("R8", LW'(wr_in_ready), LW'(0));
    else if (!wr_out_valid) check("R8", LW'(wr_in_ready), LW'(1));
    if (rd_out_valid) begin
      if (rd_q.size() == 0) check("R5", LW'(rd_out_valid), LW'(0));
      else begin
        check(rd_tag_q[0], LW'(rd_out_data), LW'(rd_q[0]));
        if (rr) begin void'(rd_q.pop_front()); void'(rd_tag_q.pop_front()); end
      end
    end
    if (wr_out_valid) begin
      if (wr_q.size() == 0) check("R7", LW'(wr_out_valid), LW'(0));
      else begin
        check("R7", wr_out_lanes, wr_q[0]);
        if (wr) void'(wr_q.pop_front());
      end
    end
    prev_rd_fire = rv && rd_in_ready;
    prev_wr_fire = wv && wr_in_ready;
    if (prev_rd_fire) begin rd_q.push_back(rdat); rd_tag_q.push_back(read_tag(bz)); end
    if (prev_wr_fire) wr_q.push_back({xor_lanes(wdat), wdat});
  endtask

  function automatic logic [DW-1:0] rnd_data();
    logic [DW-1:0] d;
    for (int i = 0; i < DW; i += 32) d[i +: 32] = $urandom();
    return d;
  endfunction

  function automatic logic [N:0] rnd_busy();
    logic [N:0] b = '0;
    if ($urandom_range(2) != 0) b[$urandom_range(N)] = 1'b1;
    return b;
  endfunction

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1: idle outputs during and just after reset
    check("R1", LW'({rd_out_valid, wr_out_valid}), LW'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", LW'({rd_out_valid, wr_out_valid}), LW'(0));

    // Directed corners: no busy, first data lane busy, last data lane busy,
    // parity device busy, all-zero and all-one data.
    step(1, {DW{1'b0}}, '0, 1, {DW{1'b1}}, 1, 1);
    step(1, {DW{1'b1}}, (N+1)'(1), 1, {DW{1'b1}}, 1, 1);             // R3 lane 0
    step(1, rnd_data(), (N+1)'(1) << (N-1), 0, '0, 1, 1);            // R3 last lane
    step(1, rnd_data(), (N+1)'(1) << N, 1, rnd_data(), 1, 1);        // R4, R8 stall
    step(1, rnd_data(), '0, 1, rnd_data(), 0, 0);                    // R6 back-pressure
    step(1, rnd_data(), '0, 1, rnd_data(), 0, 0);
    step(0, '0, '0, 0, '0, 1, 1);
    step(0, '0, '0, 0, '0, 1, 1);

    for (int c = 0; c < 4000; c++)
      step(1'($urandom_range(1)), rnd_data(), rnd_busy(),
           1'($urandom_range(1)), rnd_data(),
           1'($urandom_range(3) != 0), 1'($urandom_range(3) != 0));

    for (int c = 0; c < 4; c++) step(0, '0, '0, 0, '0, 1, 1);
    check("R5", LW'(rd_q.size()), LW'(0));
    check("R7", LW'(wr_q.size()), LW'(0));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule